// File: doc/BRIEF.md
# Main Oscillator Stop Monitor with Clock Failover

This block watches an external main oscillator using a free-running on-chip reference clock. Each main-clock rising edge flips a toggle flop. The toggle is carried into the reference domain through a two-flop synchronizer, and a change in it marks one observed edge. A counter in the reference domain counts the cycles since the last observed edge. When that count reaches a software threshold, the main clock is considered stopped.

Monitoring counts only when the two-bit arm field holds 11b and the CPU clock-source select currently picks the main clock. In that case a stop does three things:

- It forces the select field over to the chosen on-chip fallback oscillator.
- It forces the low-speed on-chip oscillator enable on.
- It sets a sticky stop flag that drives a shared interrupt line.

The watchdog and two voltage monitors feed the same interrupt line through flags of their own, so software reads the status register to find the cause. The block never returns to the main clock on its own. Software must write the select field to do that.

Software reaches the registers through a simple write port and a combinational read port:

- Address 0 is monitor control: bits [1:0] are the arm field and bit 2 is the fallback choice.
- Address 1 is clock control: bits [2:0] are the CPU source select, bit 3 is the low-speed enable and bit 4 is the high-speed enable.
- Address 2 is status: bit 0 is the oscillator stop flag, bit 1 the watchdog flag, bit 2 voltage monitor 1 and bit 3 voltage monitor 2. Writing 1 to a bit clears it.
- Address 3 is the stall threshold.

The select codes are 000 for the main clock, 001 for the low-speed on-chip oscillator and 010 for the high-speed on-chip oscillator.

Top module: `osc_fail_monitor`

## Requirements
- R1: After a synchronous active-low reset the select field reads 001, the low-speed enable is 1, the high-speed enable is 0, the arm field is 00, the fallback bit is 0, all status flags are 0, the threshold is 24 and the interrupt is low.
- R2: A write to address 0, 1 or 3 updates the addressed fields at the next reference edge, and the read port returns them in the layout given above.
- R3: No stop is acted on while the arm field holds any value other than 11b.
- R4: A stop is declared only after the reference clock has seen no synchronized main edge for threshold cycles, so a main clock whose period is well below the threshold never trips the monitor.
- R5: On a detected stop the next reference edge sets the select field to 001 when the fallback bit is 0 and to 010 when it is 1, and it sets the low-speed enable to 1. The detection takes priority over a software write in the same cycle.
- R6: A stop is ignored, leaving the select field and the flags unchanged, while the select field does not hold 000.
- R7: While the arm field holds 11b, a write to address 0 ignores its fallback bit, but the arm field itself is still written.
- R8: The stop flag is sticky and is cleared only by writing 1 to status bit 0. While the flag is set, no new failover takes place. A set and a clear in the same cycle leave the flag set.
- R9: A pulse on the watchdog, voltage-monitor-1 or voltage-monitor-2 request sets status bits 1, 2 or 3 respectively. Each bit stays set until it is cleared by writing 1 to it.
- R10: The interrupt output is high exactly when at least one status flag is set.
- R11: When the main clock resumes after a failover, the select field keeps the fallback value until software writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running on-chip reference clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| main_clk_i | input | 1 | Watched main oscillator clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| wdt_req_i | input | 1 | Watchdog interrupt request pulse |
| vmon1_req_i | input | 1 | Voltage monitor 1 request pulse |
| vmon2_req_i | input | 1 | Voltage monitor 2 request pulse |
| cpu_clk_sel_o | output | 3 | CPU clock source select |
| lso_en_o | output | 1 | Low-speed on-chip oscillator enable |
| hso_en_o | output | 1 | High-speed on-chip oscillator enable |
| irq_o | output | 1 | Shared system-monitor interrupt request |

## Verification
The main clock is first driven at periods of four and eight reference cycles under a threshold of twelve. This shows that a running clock never trips the counter, including at the slower rate. The clock is then stopped once under each of four conditions:

- armed with the low-speed fallback, which separates the 001 result from the 010 result;
- armed with the high-speed fallback;
- armed while the select field already holds 001, which shows that a stop is gated on the active source;
- with the arm field at 01, which shows that a partial arm value does nothing.

Restarting the clock after a failover, writing the main source back while the flag is still set, and pulsing the other monitor requests separate the recovery, re-fire and shared-interrupt behaviour. A reference model in the bench follows every cycle.

// File: rtl/osc_fail_pkg.sv
// Package: shared register addresses, field codes and reset values for the
// oscillator stop monitor. Assumes an 8-bit register data path.
package osc_fail_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned ARM_W   = 2;
    localparam int unsigned FLAG_N  = 4;

    localparam logic [ADDR_W-1:0] ADDR_MON    = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CLK    = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_THR    = 2'd3;

    localparam logic [SEL_W-1:0] SEL_MAIN = 3'b000;
    localparam logic [SEL_W-1:0] SEL_LSO  = 3'b001;
    localparam logic [SEL_W-1:0] SEL_HSO  = 3'b010;

    localparam logic [ARM_W-1:0] ARM_ON = 2'b11;

    // Status bit positions (software decodes these)
    localparam int unsigned FLG_OSC  = 0;
    localparam int unsigned FLG_WDT  = 1;
    localparam int unsigned FLG_VM1  = 2;
    localparam int unsigned FLG_VM2  = 3;
endpackage

// File: rtl/osc_edge_watch.sv
// Module: osc_edge_watch
// Turns main-clock rising edges into a toggle, brings the toggle into the
// reference domain through two flops, and counts reference cycles since the
// last observed change. stall_o is high while the count equals the threshold.
// Assumes the main clock runs during reset so the toggle flop gets reset.
module osc_edge_watch #(
    parameter int unsigned THR_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             main_clk_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             stall_o
);
    localparam int unsigned SYNC_N = 3;

    logic              main_tog;
    logic [SYNC_N-1:0] sync_q;
    logic [THR_W-1:0]  idle_cnt;
    logic              edge_seen;

    // Flip once per main-clock rising edge
    always_ff @(posedge main_clk_i) begin
        if (!rst_n_i) main_tog <= 1'b0;
        else          main_tog <= ~main_tog;
    end

    // Two synchronizer stages plus one history stage for change detection
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= {sync_q[SYNC_N-2:0], main_tog};
    end

    assign edge_seen = sync_q[SYNC_N-1] ^ sync_q[SYNC_N-2];

    // Count idle reference cycles, saturating at the threshold
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)               idle_cnt <= '0;
        else if (edge_seen)         idle_cnt <= '0;
        else if (idle_cnt != thr_i) idle_cnt <= idle_cnt + 1'b1;
    end

    assign stall_o = (idle_cnt == thr_i);
endmodule

// File: rtl/osc_cfg_regs.sv
// Module: osc_cfg_regs
// Holds the monitor control, clock control and threshold registers, and
// applies the failover override. The fallback bit is locked while armed.
// A detection takes priority over a same-cycle software write.
module osc_cfg_regs
    import osc_fail_pkg::*;
#(
    parameter int unsigned        THR_W     = 8,
    parameter logic [THR_W-1:0]   THR_RESET = 8'd24
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              stall_i,
    input  logic              osc_flag_i,
    output logic [ARM_W-1:0]  arm_o,
    output logic              fb_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              lso_o,
    output logic              hso_o,
    output logic [THR_W-1:0]  thr_o,
    output logic              fire_o
);
    logic wr_mon, wr_clk, wr_thr;
    logic armed;

    assign wr_mon = wr_en_i && (wr_addr_i == ADDR_MON);
    assign wr_clk = wr_en_i && (wr_addr_i == ADDR_CLK);
    assign wr_thr = wr_en_i && (wr_addr_i == ADDR_THR);
    assign armed  = (arm_o == ARM_ON);

    // Detection qualifies only when armed, main selected and flag clear
    assign fire_o = armed && (sel_o == SEL_MAIN) && stall_i && !osc_flag_i;

    // Monitor control: arm field always writable, fallback bit only unarmed
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            arm_o <= '0;
            fb_o  <= 1'b0;
        end else if (wr_mon) begin
            arm_o <= wr_data_i[ARM_W-1:0];
            if (!armed) fb_o <= wr_data_i[ARM_W];
        end
    end

    // Clock control with failover override
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            sel_o <= SEL_LSO;
            lso_o <= 1'b1;
            hso_o <= 1'b0;
        end else if (fire_o) begin
            sel_o <= fb_o ? SEL_HSO : SEL_LSO;
            lso_o <= 1'b1;
        end else if (wr_clk) begin
            sel_o <= wr_data_i[SEL_W-1:0];
            lso_o <= wr_data_i[SEL_W];
            hso_o <= wr_data_i[SEL_W+1];
        end
    end

    // Stall threshold register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)    thr_o <= THR_RESET;
        else if (wr_thr) thr_o <= wr_data_i[THR_W-1:0];
    end
endmodule

// File: rtl/osc_irq_flags.sv
// Module: osc_irq_flags
// Sticky per-source status flags behind one shared interrupt line. A set
// beats a write-one-to-clear in the same cycle.
module osc_irq_flags
    import osc_fail_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              fire_i,
    input  logic              wdt_req_i,
    input  logic              vmon1_req_i,
    input  logic              vmon2_req_i,
    input  logic              clr_en_i,
    input  logic [FLAG_N-1:0] clr_mask_i,
    output logic [FLAG_N-1:0] flags_o,
    output logic              irq_o
);
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] clr_vec;

    // Gather set requests into their status positions
    always_comb begin
        set_vec          = '0;
        set_vec[FLG_OSC] = fire_i;
        set_vec[FLG_WDT] = wdt_req_i;
        set_vec[FLG_VM1] = vmon1_req_i;
        set_vec[FLG_VM2] = vmon2_req_i;
    end

    assign clr_vec = clr_en_i ? clr_mask_i : '0;

    // One sticky flop per source
    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)        flags_o[g] <= 1'b0;
            else if (set_vec[g]) flags_o[g] <= 1'b1;
            else if (clr_vec[g]) flags_o[g] <= 1'b0;
        end
    end

    assign irq_o = |flags_o;
endmodule

// File: rtl/osc_fail_monitor.sv
// Module: osc_fail_monitor (top)
// Main-oscillator stop monitor with forced failover to an on-chip clock and
// a shared interrupt. Register read is combinational.
module osc_fail_monitor
    import osc_fail_pkg::*;
#(
    parameter int unsigned      THR_W     = 8,
    parameter logic [THR_W-1:0] THR_RESET = 8'd24
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              main_clk_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wdt_req_i,
    input  logic              vmon1_req_i,
    input  logic              vmon2_req_i,
    output logic [SEL_W-1:0]  cpu_clk_sel_o,
    output logic              lso_en_o,
    output logic              hso_en_o,
    output logic              irq_o
);
    logic              stall;
    logic              fire;
    logic [ARM_W-1:0]  arm;
    logic              fb;
    logic [THR_W-1:0]  thr;
    logic [FLAG_N-1:0] flags;
    logic              clr_en;

    assign clr_en = wr_en_i && (wr_addr_i == ADDR_STATUS);

    osc_edge_watch #(.THR_W(THR_W)) u_watch (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .main_clk_i (main_clk_i),
        .thr_i      (thr),
        .stall_o    (stall)
    );

    osc_cfg_regs #(.THR_W(THR_W), .THR_RESET(THR_RESET)) u_regs (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .stall_i    (stall),
        .osc_flag_i (flags[FLG_OSC]),
        .arm_o      (arm),
        .fb_o       (fb),
        .sel_o      (cpu_clk_sel_o),
        .lso_o      (lso_en_o),
        .hso_o      (hso_en_o),
        .thr_o      (thr),
        .fire_o     (fire)
    );

    osc_irq_flags u_flags (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .fire_i      (fire),
        .wdt_req_i   (wdt_req_i),
        .vmon1_req_i (vmon1_req_i),
        .vmon2_req_i (vmon2_req_i),
        .clr_en_i    (clr_en),
        .clr_mask_i  (wr_data_i[FLAG_N-1:0]),
        .flags_o     (flags),
        .irq_o       (irq_o)
    );

    // Register read multiplexer
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADDR_MON:    rd_data_o[ARM_W:0]     = {fb, arm};
            ADDR_CLK:    rd_data_o[SEL_W+1:0]   = {hso_en_o, lso_en_o, cpu_clk_sel_o};
            ADDR_STATUS: rd_data_o[FLAG_N-1:0]  = flags;
            default:     rd_data_o[THR_W-1:0]   = thr;
        endcase
    end
endmodule

// File: rtl/osc_fail_monitor_chk.sv
// Module: osc_fail_monitor_chk
// Temporal checks on the monitor, bound into every osc_fail_monitor.
module osc_fail_monitor_chk
    import osc_fail_pkg::*;
(
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [SEL_W-1:0]  cpu_clk_sel_o,
    input logic              lso_en_o,
    input logic              irq_o,
    input logic [ARM_W-1:0]  arm,
    input logic              fb,
    input logic              fire,
    input logic              osc_flag
);
    // R3
    unarmed_no_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (arm != ARM_ON) |=> !$rose(osc_flag));
    // R5
    failover_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        fire |=> (cpu_clk_sel_o == ($past(fb) ? SEL_HSO : SEL_LSO)) && lso_en_o);
    // R6
    not_main_no_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cpu_clk_sel_o != SEL_MAIN) |=> !$rose(osc_flag));
    // R7
    fb_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (arm == ARM_ON) |=> $stable(fb));
    // R8
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        osc_flag && !(wr_en_i && wr_addr_i == ADDR_STATUS && wr_data_i[FLG_OSC]) |=> osc_flag);
    // R10
    irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(irq_o) |-> $past(wr_en_i && wr_addr_i == ADDR_STATUS));
    // R11
    no_auto_return_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cpu_clk_sel_o != SEL_MAIN) && !(wr_en_i && wr_addr_i == ADDR_CLK)
        |=> $stable(cpu_clk_sel_o));
endmodule

bind osc_fail_monitor osc_fail_monitor_chk u_chk (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_i),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .cpu_clk_sel_o (cpu_clk_sel_o),
    .lso_en_o      (lso_en_o),
    .irq_o         (irq_o),
    .arm           (arm),
    .fb            (fb),
    .fire          (fire),
    .osc_flag      (flags[0])
);

// File: tb/osc_fail_monitor_tb_top.sv
// Bench: drives main clock and register traffic, keeps a behavioural model
// stepped once per reference cycle, and compares all outputs every cycle.
module osc_fail_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wdt = 1'b0, vm1 = 1'b0, vm2 = 1'b0;
    logic [2:0] sel;
    logic       lso, hso, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Main clock control: half period in reference cycles, 0 = stopped
    int mhalf = 2;
    int mcnt = 0;

    always #10 clk = ~clk;

    osc_fail_monitor dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .main_clk_i(main_clk),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .wdt_req_i(wdt), .vmon1_req_i(vm1), .vmon2_req_i(vm2),
        .cpu_clk_sel_o(sel), .lso_en_o(lso), .hso_en_o(hso), .irq_o(irq)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state
    int m_tog, m_prev, m_s1, m_s2, m_s3, m_cnt, m_thr;
    int m_arm, m_fb, m_sel, m_lso, m_hso, m_flags;

    function automatic int m_read(int a);
        case (a)
            0: return m_fb * 4 + m_arm;
            1: return m_hso * 16 + m_lso * 8 + m_sel;
            2: return m_flags;
            default: return m_thr;
        endcase
    endfunction

    // Model step and full comparison at every falling edge
    always @(negedge clk) begin
        int e, st, fire, fl;
        if (main_clk && !m_prev) m_tog ^= 1;
        m_prev = main_clk;
        if (!rst_n) begin
            m_tog = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_thr = 24;
            m_arm = 0; m_fb = 0; m_sel = 1; m_lso = 1; m_hso = 0; m_flags = 0;
        end else begin
            e    = (m_s2 != m_s3);
            st   = (m_cnt == m_thr);
            fire = (m_arm == 3) && (m_sel == 0) && st && !(m_flags & 1);
            if (e) m_cnt = 0; else if (!st) m_cnt++;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = m_tog;
            fl = m_flags;
            if (wr_en) case (wr_addr)
                0: begin if (m_arm != 3) m_fb = wr_data[2]; m_arm = wr_data[1:0]; end
                1: if (!fire) begin m_sel = wr_data[2:0]; m_lso = wr_data[3]; m_hso = wr_data[4]; end
                2: fl = fl & ~int'(wr_data[3:0]);
                default: m_thr = wr_data;
            endcase
            if (fire) begin m_sel = m_fb ? 2 : 1; m_lso = 1; end
            m_flags = fl | fire | (wdt << 1) | (vm1 << 2) | (vm2 << 3);
            chk("R5 sel", sel, m_sel);
            chk("R5 lso", lso, m_lso);
            chk("R2 hso", hso, m_hso);
            chk("R10 irq", irq, m_flags != 0);
            chk("R2 rd_data", rd_data, m_read(rd_addr));
        end
        // Main clock drive, after the model has sampled
        #1;
        if (mhalf > 0) begin
            mcnt++;
            if (mcnt >= mhalf) begin mcnt = 0; main_clk = ~main_clk; end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse(int which);
        if (which == 1) wdt = 1'b1; else if (which == 2) vm1 = 1'b1; else vm2 = 1'b1;
        cyc(1);
        wdt = 1'b0; vm1 = 1'b0; vm2 = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(8);                       // main runs during reset
        mhalf = 0;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk("R1 sel", sel, 1); chk("R1 lso", lso, 1); chk("R1 hso", hso, 0); chk("R1 irq", irq, 0);
        rd_addr = 2'd3; #1 chk("R1 thr", rd_data, 24);
        rd_addr = 2'd0; #1 chk("R1 mon", rd_data, 0);
        // R2 setup: threshold 12, main source, both oscillators on
        wr(2'd3, 8'd12);
        wr(2'd1, 8'h18);
        rd_addr = 2'd1; #1 chk("R2 clk reg", rd_data, 8'h18);
        mhalf = 2; cyc(20);
        wr(2'd0, 8'h03);              // arm, low-speed fallback
        cyc(200);
        chk("R4 period 4 no trip", sel, 0);
        mhalf = 4; cyc(200);
        chk("R4 period 8 no trip", sel, 0);
        // R7: fallback bit write ignored while armed
        wr(2'd0, 8'h07);
        rd_addr = 2'd0; #1 chk("R7 fb locked", rd_data, 3);
        // R4/R5: stop main, low-speed fallback
        mhalf = 0; cyc(40);
        chk("R5 low-speed failover", sel, 1);
        chk("R8 flag set", irq, 1);
        // R11: restart main, stays on fallback
        mhalf = 2; cyc(60);
        chk("R11 no auto return", sel, 1);
        // R8: writing main back while flag set, with main stopped
        mhalf = 0; cyc(10);
        wr(2'd1, 8'h18); cyc(40);
        chk("R8 no refire while flag set", sel, 0);
        wr(2'd2, 8'h01); cyc(2);
        chk("R8 cleared then refire", sel, 1);
        wr(2'd2, 8'h01);
        rd_addr = 2'd2; #1 chk("R8 flag cleared", rd_data, 0);
        // R9/R10: other sources share the line
        pulse(1); pulse(3);
        chk("R9 wdt+vm2 flags", rd_data, 8'h0A);
        chk("R10 irq shared", irq, 1);
        wr(2'd2, 8'h02); chk("R9 vm2 still set", rd_data, 8'h08);
        pulse(2); wr(2'd2, 8'h0C);
        chk("R10 irq low", irq, 0);
        // R5: high-speed fallback
        wr(2'd0, 8'h00); wr(2'd0, 8'h04); wr(2'd0, 8'h07);
        mhalf = 2; cyc(20);
        wr(2'd1, 8'h18); cyc(20);
        mhalf = 0; cyc(40);
        chk("R5 high-speed failover", sel, 2);
        wr(2'd2, 8'h01);
        // R6: select already on low-speed, armed, main stopped
        wr(2'd1, 8'h19); cyc(40);
        rd_addr = 2'd2; #1 chk("R6 no flag", rd_data, 0);
        chk("R6 sel kept", sel, 1);
        // R3: partial arm value
        wr(2'd0, 8'h01); wr(2'd1, 8'h18); cyc(40);
        chk("R3 no trip arm 01", sel, 0);
        chk("R3 no irq", irq, 0);
        cyc(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule